// File: doc/BRIEF.md
# Data link byte receiver with zero destuffing

This block takes a serial data link bit stream that an upstream framer has already pulled out of the line frame. It receives one bit each time a strobe is qualified. The block can optionally discard HDLC-style stuffed zeros. It then packs the surviving bits into bytes, least significant bit first.

Each finished byte is latched for the host and compared against two programmable match bytes. Two sticky status flags report the result: byte-ready and match. Each flag has its own interrupt enable, and the two share one active-low interrupt line. With the match interrupt alone enabled, a host can sleep through ordinary traffic and wake only when a byte of interest arrives. A third sticky flag records that a byte was overwritten before the host cleared the byte-ready flag. A byte-wide register port gives access to the received byte, the two match bytes, a control register and the status register.

Top module: `fdl_link_rx`

## Requirements
- R1: A bit is accepted on a clock edge where `bit_strobe` is high and the bit is not removed as stuffing. Each accepted bit enters the top of the assembly register, so the first accepted bit becomes bit 0 of the byte. After eight accepted bits, the byte can be read at address 0x28 from the clock edge after the eighth bit.
- R2: Completing a byte sets status bit 0 (byte-ready) at address 0x2C. While that bit and control bit 1 (byte-ready enable) at address 0x2B are both set, `irq_n` is low.
- R3: The match registers are readable and writable at address 0x29 (match A) and address 0x2A (match B). A completed byte equal to either of them sets status bit 1 (match). A byte equal to neither leaves the match bit unchanged.
- R4: `irq_n` is low while status bit 1 and control bit 2 (match enable) are both set. A status bit whose enable is clear never pulls `irq_n` low.
- R5: When control bit 0 (destuff enable) is set, a zero received right after exactly five consecutive accepted ones is discarded. The discarded zero does not advance the bit count, and it ends the run of ones.
- R6: With destuffing enabled, a zero that follows six or more consecutive ones is kept as a data bit.
- R7: With destuffing disabled, every strobed bit is kept, including a zero that follows five ones.
- R8: Writing a one to a status bit at address 0x2C clears it. Writing a zero leaves it unchanged. `irq_n` returns high once no enabled status bit is set.
- R9: If a byte completes while status bit 0 is already set, status bit 2 (overrun) is set and the new byte replaces the old one at address 0x28.
- R10: If a byte completes in the same cycle as a host write that clears status bits, the flags the completion sets stay set. The overrun flag depends on the byte-ready flag as it stood before that write.
- R11: After reset, every register reads zero, no bit is held in assembly and `irq_n` is high.
- R12: While `bit_strobe` is low, `bit_in` has no effect on the received byte or on the bit count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_strobe | input | 1 | Qualifies `bit_in` for one cycle |
| bit_in | input | 1 | Serial data link bit |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A byte can complete in the same clock cycle that the host writes to the status register to clear flags. That is the one place where hardware setting a flag and software clearing it collide. The bench provokes it on purpose: it places the eighth strobe in the same cycle as a write-one-to-clear, once with byte-ready idle and once with it already set. It then expects byte-ready to stay set, and expects overrun to follow the earlier byte-ready value. Randomized bursts also land clears on strobe cycles, and a bench model decides each outcome by applying the clear first and then the set.

// File: rtl/fdl_rx_pkg.sv
package fdl_rx_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int RUN_LIMIT = 5;
    localparam int RUN_W     = 3;

    localparam logic [ADDR_W-1:0] ADDR_RXBYTE = 8'h28;
    localparam logic [ADDR_W-1:0] ADDR_MATCHA = 8'h29;
    localparam logic [ADDR_W-1:0] ADDR_MATCHB = 8'h2A;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 8'h2B;
    localparam logic [ADDR_W-1:0] ADDR_STAT   = 8'h2C;

    // bit 0 destuff enable, bit 1 byte-ready enable, bit 2 match enable
    typedef struct packed {
        logic match_ie;
        logic full_ie;
        logic destuff_en;
    } ctrl_t;

    // bit 0 byte-ready, bit 1 match, bit 2 overrun
    typedef struct packed {
        logic ovr;
        logic match;
        logic full;
    } stat_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int STAT_W = $bits(stat_t);

    function automatic logic [RUN_W-1:0] run_step(input logic [RUN_W-1:0] cur,
                                                  input logic one,
                                                  input logic [RUN_W-1:0] sat);
        if (!one)
            return '0;
        else if (cur == sat)
            return sat;
        else
            return cur + 1'b1;
    endfunction

endpackage

// File: rtl/fdl_destuff.sv
module fdl_destuff
    import fdl_rx_pkg::*;
#(
    parameter int LIMIT = RUN_LIMIT,
    parameter int CW    = RUN_W
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic strobe,
    input  logic din,
    output logic accept
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);
    localparam logic [CW-1:0] SAT = CW'(LIMIT + 1);

    logic [CW-1:0] run_q;
    logic          stuffed;

    assign stuffed = en && strobe && !din && (run_q == LIM);
    assign accept  = strobe && !stuffed;

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (!en)
            run_q <= '0;
        else if (strobe)
            run_q <= run_step(run_q, din, SAT);
    end

    assert_run_held_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> run_q == '0);

    assert_run_bound_R6: assert property (@(posedge clk) disable iff (rst)
        run_q <= SAT);

    assert_zero_ends_run_R5: assert property (@(posedge clk) disable iff (rst)
        (strobe && !din) |=> run_q == '0);

endmodule

// File: rtl/fdl_byte_asm.sv
module fdl_byte_asm
    import fdl_rx_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         accept,
    input  logic         din,
    output logic         done,
    output logic [W-1:0] byte_out
);
    localparam int            CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [W-2:0]     part_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     shifted;

    assign shifted  = {din, part_q};
    assign done     = accept && (cnt_q == LAST);
    assign byte_out = shifted;

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q <= '0;
            cnt_q  <= '0;
        end else if (accept) begin
            part_q <= shifted[W-1:1];
            cnt_q  <= done ? '0 : cnt_q + 1'b1;
        end
    end

    assert_count_stall_R12: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(cnt_q) && $stable(part_q));

    assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        done |=> cnt_q == '0);

endmodule

// File: rtl/fdl_regs.sv
module fdl_regs
    import fdl_rx_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [W-1:0]      byte_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    output logic              destuff_en,
    output logic              irq_n
);
    logic [W-1:0] rx_q, ma_q, mb_q;
    ctrl_t        ctrl_q;
    stat_t        stat_q, clr, stat_d;
    logic         hit;

    assign clr = (reg_wr && reg_addr == ADDR_STAT) ? stat_t'(reg_wdata[STAT_W-1:0]) : '0;
    assign hit = done && ((byte_in == ma_q) || (byte_in == mb_q));

    always_comb begin
        stat_d.full  = done | (stat_q.full  & ~clr.full);
        stat_d.match = hit  | (stat_q.match & ~clr.match);
        stat_d.ovr   = (done & stat_q.full) | (stat_q.ovr & ~clr.ovr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q   <= '0;
            ma_q   <= '0;
            mb_q   <= '0;
            ctrl_q <= '0;
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
            if (done)
                rx_q <= byte_in;
            if (reg_wr) begin
                case (reg_addr)
                    ADDR_MATCHA: ma_q   <= reg_wdata;
                    ADDR_MATCHB: mb_q   <= reg_wdata;
                    ADDR_CTRL:   ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_RXBYTE: reg_rdata = rx_q;
            ADDR_MATCHA: reg_rdata = ma_q;
            ADDR_MATCHB: reg_rdata = mb_q;
            ADDR_CTRL:   reg_rdata = W'(ctrl_q);
            ADDR_STAT:   reg_rdata = W'(stat_q);
            default:     reg_rdata = '0;
        endcase
    end

    assign destuff_en = ctrl_q.destuff_en;
    assign irq_n = !((stat_q.full && ctrl_q.full_ie) || (stat_q.match && ctrl_q.match_ie));

    assert_full_set_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> stat_q.full);

    assert_match_a_R3: assert property (@(posedge clk) disable iff (rst)
        (done && byte_in == ma_q) |=> stat_q.match);

    assert_overrun_R9: assert property (@(posedge clk) disable iff (rst)
        (done && stat_q.full) |=> stat_q.ovr && rx_q == $past(byte_in));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_q.full && !(reg_wr && reg_addr == ADDR_STAT)) |=> stat_q.full);

    assert_quiet_irq_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.full_ie && !ctrl_q.match_ie) |-> irq_n);

endmodule

// File: rtl/fdl_link_rx.sv
module fdl_link_rx
    import fdl_rx_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_strobe,
    input  logic              bit_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    output logic              irq_n
);
    logic         destuff_en;
    logic         accept;
    logic         done;
    logic [W-1:0] new_byte;

    fdl_destuff #(.LIMIT(RUN_LIMIT), .CW(RUN_W)) u_destuff (
        .clk    (clk),
        .rst    (rst),
        .en     (destuff_en),
        .strobe (bit_strobe),
        .din    (bit_in),
        .accept (accept)
    );

    fdl_byte_asm #(.W(W)) u_asm (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .din      (bit_in),
        .done     (done),
        .byte_out (new_byte)
    );

    fdl_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .done       (done),
        .byte_in    (new_byte),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .destuff_en (destuff_en),
        .irq_n      (irq_n)
    );

endmodule

// File: tb/sim_fdl_link_rx.sv
module sim_fdl_link_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_strobe = 1'b0;
    logic       bit_in = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_n;

    always #10 clk = ~clk;

    fdl_link_rx u0 (
        .clk(clk), .rst(rst), .bit_strobe(bit_strobe), .bit_in(bit_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // reference model state
    logic       m_en = 0, m_ief = 0, m_iem = 0;
    int         m_ones = 0, m_cnt = 0;
    logic [7:0] m_sr = 0, m_byte = 0, m_a = 0, m_b = 0;
    logic       m_full = 0, m_match = 0, m_ovr = 0;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic mbit(input logic b, input logic en, input logic [7:0] ma, input logic [7:0] mb,
                        input logic full_old);
        if (en && !b && m_ones == 5) begin
            m_ones = 0;
            return;
        end
        m_ones = !en ? 0 : (b ? ((m_ones >= 6) ? 6 : m_ones + 1) : 0);
        m_sr = {b, m_sr[7:1]};
        m_cnt++;
        if (m_cnt == 8) begin
            m_cnt  = 0;
            m_byte = m_sr;
            if (full_old) m_ovr = 1;
            m_full = 1;
            if (m_sr == ma || m_sr == mb) m_match = 1;
        end
    endtask

    task automatic cycle(input logic s, input logic b, input logic w,
                         input logic [7:0] a, input logic [7:0] d);
        logic       en0, full0;
        logic [7:0] a0, b0;
        en0 = m_en; full0 = m_full; a0 = m_a; b0 = m_b;
        @(negedge clk);
        bit_strobe = s; bit_in = b; reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        bit_strobe = 1'b0; reg_wr = 1'b0;
        if (w) begin
            case (a)
                8'h29: m_a = d;
                8'h2A: m_b = d;
                8'h2B: begin m_en = d[0]; m_ief = d[1]; m_iem = d[2]; end
                8'h2C: begin
                    if (d[0]) m_full = 0;
                    if (d[1]) m_match = 0;
                    if (d[2]) m_ovr = 0;
                end
                default: ;
            endcase
        end
        if (s) mbit(b, en0, a0, b0, full0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cycle(1'b0, 1'b0, 1'b1, a, d);
    endtask

    task automatic sbit(input logic b);
        cycle(1'b1, b, 1'b0, 8'h00, 8'h00);
    endtask

    task automatic sbyte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) sbit(v[i]);
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic check_model(input string tag);
        rd_check({tag, " byte"}, 8'h28, m_byte);
        rd_check({tag, " stat"}, 8'h2C, {5'b0, m_ovr, m_match, m_full});
        rd_check({tag, " ctrl"}, 8'h2B, {5'b0, m_iem, m_ief, m_en});
        check({tag, " irq_n"}, irq_n, !((m_full && m_ief) || (m_match && m_iem)));
    endtask

    task automatic send_list(input logic [15:0] bits, input int n);
        for (int i = 0; i < n; i++) sbit(bits[i]);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        rd_check("R11 rxbyte", 8'h28, 8'h00);
        rd_check("R11 matchA", 8'h29, 8'h00);
        rd_check("R11 matchB", 8'h2A, 8'h00);
        rd_check("R11 ctrl", 8'h2B, 8'h00);
        rd_check("R11 stat", 8'h2C, 8'h00);
        check("R11 irq_n", irq_n, 1'b1);

        // R1 LSB first, destuff off
        sbyte(8'hA5);
        rd_check("R1 byte A5", 8'h28, 8'hA5);
        rd_check("R2 full set", 8'h2C, 8'h01);
        check("R4 masked irq_n", irq_n, 1'b1);
        wr(8'h2B, 8'h02);
        check("R2 irq_n low", irq_n, 1'b0);
        wr(8'h2C, 8'h00);
        rd_check("R8 write zero keeps", 8'h2C, 8'h01);
        wr(8'h2C, 8'h01);
        rd_check("R8 cleared", 8'h2C, 8'h00);
        check("R8 irq_n high", irq_n, 1'b1);

        // R3 match registers
        wr(8'h29, 8'h3C);
        wr(8'h2A, 8'hC3);
        rd_check("R3 matchA rw", 8'h29, 8'h3C);
        rd_check("R3 matchB rw", 8'h2A, 8'hC3);
        sbyte(8'h3C);
        rd_check("R3 hit A", 8'h2C, 8'h03);
        wr(8'h2C, 8'h03);
        sbyte(8'hC3);
        rd_check("R3 hit B", 8'h2C, 8'h03);
        wr(8'h2C, 8'h03);
        sbyte(8'h55);
        rd_check("R3 no hit", 8'h2C, 8'h01);
        wr(8'h2C, 8'h07);

        // R4 match interrupt only
        wr(8'h2B, 8'h04);
        sbyte(8'h55);
        check("R4 full masked irq_n", irq_n, 1'b1);
        sbyte(8'h3C);
        check("R4 match irq_n low", irq_n, 1'b0);
        wr(8'h2C, 8'h02);
        check("R4 match cleared irq_n", irq_n, 1'b1);
        rd_check("R8 only match cleared", 8'h2C, 8'h05);
        wr(8'h2C, 8'h07);
        wr(8'h2B, 8'h00);

        // R7 destuff off keeps zero after five ones: 1,1,1,1,1,0,1,0
        send_list(16'b0000_0000_0101_1111, 8);
        rd_check("R7 zero kept", 8'h28, 8'h5F);
        wr(8'h2C, 8'h07);

        // R5 destuff on: 1,1,1,1,1,0(dropped),1,0,0
        wr(8'h2B, 8'h01);
        send_list(16'b0000_0000_0101_1111, 8);
        rd_check("R5 count stalled", 8'h2C, 8'h00);
        sbit(1'b0);
        rd_check("R5 stuffed dropped", 8'h28, 8'h3F);
        wr(8'h2C, 8'h07);

        // R6 six ones then zero kept: 1x6,0,1
        send_list(16'b0000_0000_1011_1111, 8);
        rd_check("R6 zero after six kept", 8'h28, 8'hBF);
        rd_check("R6 full", 8'h2C, 8'h01);
        wr(8'h2C, 8'h07);
        wr(8'h2B, 8'h00);

        // R12 strobe low ignored
        send_list(16'h0006, 4);
        for (int i = 0; i < 6; i++) cycle(1'b0, i[0], 1'b0, 8'h00, 8'h00);
        rd_check("R12 no byte yet", 8'h2C, 8'h00);
        send_list(16'h0009, 4);
        rd_check("R12 byte", 8'h28, 8'h96);

        // R9 overrun
        sbyte(8'h22);
        rd_check("R9 overrun", 8'h2C, 8'h05);
        rd_check("R9 replaced", 8'h28, 8'h22);
        wr(8'h2C, 8'h07);

        // R10 completion with clear in same cycle
        send_list(16'h0044, 7);
        cycle(1'b1, 1'b0, 1'b1, 8'h2C, 8'h07);
        rd_check("R10 set wins", 8'h2C, 8'h01);
        send_list(16'h0011, 7);
        cycle(1'b1, 1'b0, 1'b1, 8'h2C, 8'h07);
        rd_check("R10 overrun from old full", 8'h2C, 8'h05);
        rd_check("R10 byte", 8'h28, 8'h11);
        check_model("R10 model");

        // random phase
        for (int burst = 0; burst < 400; burst++) begin
            logic [7:0] c;
            int n;
            c = 8'($urandom_range(0, 7));
            wr(8'h2B, c);
            if ($urandom_range(0, 3) == 0) wr(8'h29, ($urandom_range(0, 1) != 0) ? m_byte : 8'($urandom));
            if ($urandom_range(0, 3) == 0) wr(8'h2A, 8'hFF);
            n = $urandom_range(1, 24);
            for (int k = 0; k < n; k++) begin
                logic b;
                b = ($urandom_range(0, 9) < 7);
                case ($urandom_range(0, 7))
                    0: cycle(1'b1, b, 1'b1, 8'h2C, 8'($urandom_range(0, 7)));
                    1: cycle(1'b0, b, 1'b0, 8'h00, 8'h00);
                    default: sbit(b);
                endcase
            end
            check_model((m_en ? "R5 R6 rand" : "R7 R1 rand"));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule